// File: doc/BRIEF.md
# Debug Probe Target Isolation Front End

This block is the target-facing pin stage of a debug probe that speaks either a four-wire boundary-scan link (JTAG) or a two-wire serial debug link (SWD). A host-side serial engine generates clock, mode-select and data bits. This block routes those bits onto the target connector through a mode-selected multiplexer and drives the tristate enable of each pin. Signals returning from the target pass straight back to the host side: test data out, the returned clock, and the serial data line when it is read. The routing is purely combinational.

The block keeps one bit of state, a sticky power-fault flag. When the target's power-good indication drops, the flag is set and every target-facing driver is released to high impedance. The only exception is a set of emulation-mode pins, each of which the host may choose to hold low while the fault lasts. The flag stays set until power is good again and the host then flips a dedicated acknowledge line. After reset the flag is set, so the probe starts with its pins released.

The power-good and acknowledge inputs are asynchronous and pass through synchronizers inside the block. The block has no data stream: every port is a plain control, status or pin signal, and none of them has a handshake or back-pressure.

Top module: `probe_target_frontend`

## Requirements
- R1: On reset, `tgt_fault` reads 1 and every output enable (`tgt_tck_oe`, `tgt_tms_oe`, `tgt_tdi_oe`, `tgt_emu_oe`) reads 0 while no emulation hold is requested.
- R2: With `swd_mode`=0 and no fault, `tgt_tck_o`, `tgt_tms_o` and `tgt_tdi_o` follow `host_tck`, `host_tms` and `host_tdi` combinationally, and all three enables read 1.
- R3: With `swd_mode`=1 and no fault, the TMS pin carries the serial data line. `tgt_tms_o`=`host_swdio_out` and `tgt_tms_oe`=`host_swdio_dir` (1 means the probe drives). `tgt_tck_oe`=1, `tgt_tdi_oe`=0, and `host_swdio_in` reflects `tgt_tms_i`.
- R4: `host_tdo`=`tgt_tdo_i` and `host_rtck`=`tgt_rtck_i` combinationally, in both modes and whether or not a fault is present.
- R5: After `pwr_good` falls, `tgt_fault` is still 0 after two rising clock edges and reads 1 after the third.
- R6: While `tgt_fault` is 1, `tgt_tck_oe`, `tgt_tms_oe` and `tgt_tdi_oe` are all 0, in either mode and whatever the host direction input.
- R7: While `tgt_fault` is 1, `tgt_emu_oe[i]`=`emu_hold[i]` and `tgt_emu_o[i]`=0 for each pin i. While `tgt_fault` is 0, every `tgt_emu_oe` bit is 0.
- R8: With power good, either edge of `ack_toggle` clears `tgt_fault` on the third rising clock edge after the edge.
- R9: An `ack_toggle` edge seen while power is bad is discarded: `tgt_fault` stays 1 after power returns until a further edge arrives.
- R10: A brief low pulse on `pwr_good` sets `tgt_fault`, and the return of power by itself never clears it.
- R11: If power is bad in the same cycle as an acknowledge edge, the set wins and `tgt_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swd_mode | input | 1 | 0 = four-wire scan routing, 1 = two-wire serial routing |
| host_tck | input | 1 | Clock from the host engine |
| host_tms | input | 1 | Mode-select bit from the host (scan mode) |
| host_tdi | input | 1 | Data-in bit from the host (scan mode) |
| host_swdio_out | input | 1 | Serial data bit from the host (serial mode) |
| host_swdio_dir | input | 1 | 1 = probe drives the serial data line |
| host_tdo | output | 1 | Target test data out, returned to the host |
| host_rtck | output | 1 | Target returned clock, passed to the host |
| host_swdio_in | output | 1 | Level read on the serial data line |
| emu_hold | input | N_EMU | Per-pin request to hold an emulation pin low during a fault |
| ack_toggle | input | 1 | Asynchronous acknowledge line; any edge acknowledges |
| pwr_good | input | 1 | Asynchronous target power-good indication |
| tgt_fault | output | 1 | Power-fault flag status |
| tgt_tck_o | output | 1 | Clock pin value |
| tgt_tck_oe | output | 1 | Clock pin enable |
| tgt_tms_o | output | 1 | TMS / serial data pin value |
| tgt_tms_oe | output | 1 | TMS / serial data pin enable |
| tgt_tms_i | input | 1 | TMS / serial data pin level |
| tgt_tdi_o | output | 1 | Data-in pin value |
| tgt_tdi_oe | output | 1 | Data-in pin enable |
| tgt_tdo_i | input | 1 | Data-out pin level from the target |
| tgt_rtck_i | input | 1 | Returned clock pin level |
| tgt_emu_o | output | N_EMU | Emulation pin values |
| tgt_emu_oe | output | N_EMU | Emulation pin enables |

## Verification
The bench builds the block with SYNC_STAGES=2 and N_EMU=2. With a two-stage synchronizer, the latencies for setting and clearing the flag are exactly three edges, so the bench can sample on both sides of the edge where the flag changes. With two emulation pins, every combination of hold requests can be applied during one fault, which shows that each pin is controlled on its own. The acknowledge and power sequences are ordered so that an early acknowledge, a bare power pulse and a collision between set and clear each show up as the flag staying set.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic {
    LINK_SCAN   = 1'b0,
    LINK_SERIAL = 1'b1
  } link_mode_e;

  typedef struct packed {
    logic tck_o;
    logic tck_oe;
    logic tms_o;
    logic tms_oe;
    logic tdi_o;
    logic tdi_oe;
  } pin_drive_t;
endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/probe_fault_latch.sv
module probe_fault_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_async,
  input  logic ack_async,
  output logic fault
);
  logic pg_s;
  logic ack_s;
  logic ack_d;
  logic ack_edge;

  probe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .d(pwr_good_async), .q(pg_s)
  );

  probe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_d <= 1'b0;
    else        ack_d <= ack_s;
  end

  assign ack_edge = ack_s ^ ack_d;

  // Loss of power dominates; release needs power plus an acknowledge edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fault <= 1'b1;
    else if (!pg_s)             fault <= 1'b1;
    else if (ack_edge)          fault <= 1'b0;
  end

  // R5
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> fault);

  // R8
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> ($past(pg_s) && $past(ack_edge)));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(pg_s && ack_edge)) |=> fault);
endmodule

// File: rtl/probe_pin_mux.sv
module probe_pin_mux
  import probe_pkg::*;
(
  input  link_mode_e mode,
  input  logic       fault,
  input  logic       host_tck,
  input  logic       host_tms,
  input  logic       host_tdi,
  input  logic       host_swdio_out,
  input  logic       host_swdio_dir,
  input  logic       tgt_tms_i,
  input  logic       tgt_tdo_i,
  input  logic       tgt_rtck_i,
  output pin_drive_t drv,
  output logic       host_tdo,
  output logic       host_rtck,
  output logic       host_swdio_in
);
  always_comb begin
    drv = '0;
    if (!fault) begin
      drv.tck_o  = host_tck;
      drv.tck_oe = 1'b1;
      if (mode == LINK_SERIAL) begin
        drv.tms_o  = host_swdio_out;
        drv.tms_oe = host_swdio_dir;
      end else begin
        drv.tms_o  = host_tms;
        drv.tms_oe = 1'b1;
        drv.tdi_o  = host_tdi;
        drv.tdi_oe = 1'b1;
      end
    end
  end

  assign host_tdo      = tgt_tdo_i;
  assign host_rtck     = tgt_rtck_i;
  assign host_swdio_in = tgt_tms_i;
endmodule

// File: rtl/probe_emu_hold.sv
module probe_emu_hold #(
  parameter int N_EMU = 2
) (
  input  logic             fault,
  input  logic [N_EMU-1:0] hold,
  output logic [N_EMU-1:0] emu_o,
  output logic [N_EMU-1:0] emu_oe
);
  for (genvar i = 0; i < N_EMU; i++) begin : g_pin
    assign emu_o[i]  = 1'b0;
    assign emu_oe[i] = fault & hold[i];
  end
endmodule

// File: rtl/probe_target_frontend.sv
module probe_target_frontend
  import probe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_EMU       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swd_mode,
  input  logic             host_tck,
  input  logic             host_tms,
  input  logic             host_tdi,
  input  logic             host_swdio_out,
  input  logic             host_swdio_dir,
  output logic             host_tdo,
  output logic             host_rtck,
  output logic             host_swdio_in,
  input  logic [N_EMU-1:0] emu_hold,
  input  logic             ack_toggle,
  input  logic             pwr_good,
  output logic             tgt_fault,
  output logic             tgt_tck_o,
  output logic             tgt_tck_oe,
  output logic             tgt_tms_o,
  output logic             tgt_tms_oe,
  input  logic             tgt_tms_i,
  output logic             tgt_tdi_o,
  output logic             tgt_tdi_oe,
  input  logic             tgt_tdo_i,
  input  logic             tgt_rtck_i,
  output logic [N_EMU-1:0] tgt_emu_o,
  output logic [N_EMU-1:0] tgt_emu_oe
);
  pin_drive_t drv;
  link_mode_e mode;

  assign mode = link_mode_e'(swd_mode);

  probe_fault_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .pwr_good_async(pwr_good), .ack_async(ack_toggle),
    .fault(tgt_fault)
  );

  probe_pin_mux u_mux (
    .mode(mode), .fault(tgt_fault),
    .host_tck(host_tck), .host_tms(host_tms), .host_tdi(host_tdi),
    .host_swdio_out(host_swdio_out), .host_swdio_dir(host_swdio_dir),
    .tgt_tms_i(tgt_tms_i), .tgt_tdo_i(tgt_tdo_i), .tgt_rtck_i(tgt_rtck_i),
    .drv(drv), .host_tdo(host_tdo), .host_rtck(host_rtck),
    .host_swdio_in(host_swdio_in)
  );

  probe_emu_hold #(.N_EMU(N_EMU)) u_emu (
    .fault(tgt_fault), .hold(emu_hold),
    .emu_o(tgt_emu_o), .emu_oe(tgt_emu_oe)
  );

  assign tgt_tck_o  = drv.tck_o;
  assign tgt_tck_oe = drv.tck_oe;
  assign tgt_tms_o  = drv.tms_o;
  assign tgt_tms_oe = drv.tms_oe;
  assign tgt_tdi_o  = drv.tdi_o;
  assign tgt_tdi_oe = drv.tdi_oe;

  // R6
  pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_fault |-> !(tgt_tck_oe || tgt_tms_oe || tgt_tdi_oe));

  // R7
  emu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_fault |-> (tgt_emu_oe == '0));
endmodule

// File: tb/probe_target_frontend_test.sv
`timescale 1ns/100ps
module probe_target_frontend_test;
  localparam int N_EMU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swd_mode = 1'b0, host_tck = 1'b0, host_tms = 1'b0, host_tdi = 1'b0;
  logic host_swdio_out = 1'b0, host_swdio_dir = 1'b0;
  logic host_tdo, host_rtck, host_swdio_in;
  logic [N_EMU-1:0] emu_hold = '0;
  logic ack_toggle = 1'b0, pwr_good = 1'b1;
  logic tgt_fault, tgt_tck_o, tgt_tck_oe, tgt_tms_o, tgt_tms_oe, tgt_tdi_o, tgt_tdi_oe;
  logic tgt_tms_i = 1'b0, tgt_tdo_i = 1'b0, tgt_rtck_i = 1'b0;
  logic [N_EMU-1:0] tgt_emu_o, tgt_emu_oe;

  always #2.5 clk = ~clk;

  probe_target_frontend #(.SYNC_STAGES(2), .N_EMU(N_EMU)) uut (
    .clk(clk), .rst_n(rst_n), .swd_mode(swd_mode),
    .host_tck(host_tck), .host_tms(host_tms), .host_tdi(host_tdi),
    .host_swdio_out(host_swdio_out), .host_swdio_dir(host_swdio_dir),
    .host_tdo(host_tdo), .host_rtck(host_rtck), .host_swdio_in(host_swdio_in),
    .emu_hold(emu_hold), .ack_toggle(ack_toggle), .pwr_good(pwr_good),
    .tgt_fault(tgt_fault), .tgt_tck_o(tgt_tck_o), .tgt_tck_oe(tgt_tck_oe),
    .tgt_tms_o(tgt_tms_o), .tgt_tms_oe(tgt_tms_oe), .tgt_tms_i(tgt_tms_i),
    .tgt_tdi_o(tgt_tdi_o), .tgt_tdi_oe(tgt_tdi_oe), .tgt_tdo_i(tgt_tdo_i),
    .tgt_rtck_i(tgt_rtck_i), .tgt_emu_o(tgt_emu_o), .tgt_emu_oe(tgt_emu_oe)
  );

  // Observation selectors
  localparam int OBS_FAULT = 0;  // {fault}
  localparam int OBS_OE    = 1;  // {tck_oe, tms_oe, tdi_oe}
  localparam int OBS_DATA  = 2;  // {tck_o, tms_o, tdi_o}
  localparam int OBS_EMUOE = 3;  // emu_oe
  localparam int OBS_RET   = 4;  // {host_tdo, host_rtck, host_swdio_in}
  localparam int OBS_EMUO  = 5;  // emu_o

  typedef struct {
    string      req;
    int         sel;
    logic [3:0] exp;
  } exp_item_t;

  exp_item_t sb[$];
  exp_item_t item;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit reported = 1'b0;

  function automatic logic [3:0] observe(int sel);
    case (sel)
      OBS_FAULT: return {3'b0, tgt_fault};
      OBS_OE:    return {1'b0, tgt_tck_oe, tgt_tms_oe, tgt_tdi_oe};
      OBS_DATA:  return {1'b0, tgt_tck_o, tgt_tms_o, tgt_tdi_o};
      OBS_EMUOE: return {2'b0, tgt_emu_oe};
      OBS_RET:   return {1'b0, host_tdo, host_rtck, host_swdio_in};
      default:   return {2'b0, tgt_emu_o};
    endcase
  endfunction

  // Monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item = sb.pop_front();
      checks++;
      if (observe(item.sel) !== item.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%b expected=%b",
                 item.req, item.sel, observe(item.sel), item.exp);
      end
    end
  end

  task automatic push(string req, int sel, logic [3:0] v);
    sb.push_back('{req, sel, v});
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic flip_ack();
    ack_toggle = ~ack_toggle;
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1: flag set after reset, nothing driven
    push("R1", OBS_FAULT, 4'd1);
    push("R1", OBS_OE, 4'b000);
    push("R1", OBS_EMUOE, 4'b00);
    step(1);

    // R8: acknowledge with power good clears on the third edge
    flip_ack();
    step(2);
    push("R8", OBS_FAULT, 4'd1);
    step(1);
    push("R8", OBS_FAULT, 4'd0);
    push("R7", OBS_EMUOE, 4'b00);
    step(1);

    // R2: scan routing for every input pattern
    for (int p = 0; p < 8; p++) begin
      {host_tck, host_tms, host_tdi} = 3'(p);
      #0.5;
      push("R2", OBS_DATA, 4'(p));
      push("R2", OBS_OE, 4'b111);
      step(1);
    end

    // R4: return path in scan mode
    for (int p = 0; p < 4; p++) begin
      {tgt_tdo_i, tgt_rtck_i} = 2'(p);
      tgt_tms_i = p[0];
      #0.5;
      push("R4", OBS_RET, {1'b0, 2'(p), p[0]});
      step(1);
    end

    // R3: serial routing
    swd_mode = 1'b1;
    host_tms = 1'b0;
    host_swdio_dir = 1'b1;
    host_swdio_out = 1'b1;
    host_tck = 1'b1;
    #0.5;
    push("R3", OBS_OE, 4'b110);
    push("R3", OBS_DATA, 4'b110);
    step(1);
    host_swdio_out = 1'b0;
    #0.5;
    push("R3", OBS_DATA, 4'b100);
    step(1);
    host_swdio_dir = 1'b0;
    tgt_tms_i = 1'b1;
    tgt_tdo_i = 1'b0;
    tgt_rtck_i = 1'b1;
    #0.5;
    push("R3", OBS_OE, 4'b100);
    push("R3", OBS_RET, 4'b011);
    step(1);
    tgt_tms_i = 1'b0;
    #0.5;
    push("R3", OBS_RET, 4'b010);
    step(1);

    // R5: power loss latency
    host_swdio_dir = 1'b1;
    pwr_good = 1'b0;
    step(2);
    push("R5", OBS_FAULT, 4'd0);
    step(1);
    push("R5", OBS_FAULT, 4'd1);
    // R6: released in serial mode with direction requesting drive
    push("R6", OBS_OE, 4'b000);
    step(1);
    swd_mode = 1'b0;
    #0.5;
    push("R6", OBS_OE, 4'b000);
    // R4: return path still live during the fault
    tgt_tdo_i = 1'b1;
    tgt_rtck_i = 1'b0;
    #0.5;
    push("R4", OBS_RET, 4'b100);
    step(1);

    // R7: every hold combination during the fault
    for (int h = 0; h < 4; h++) begin
      emu_hold = 2'(h);
      #0.5;
      push("R7", OBS_EMUOE, 4'(h));
      push("R7", OBS_EMUO, 4'b00);
      step(1);
    end

    // R9: acknowledge while power is bad is discarded
    flip_ack();
    step(6);
    push("R9", OBS_FAULT, 4'd1);
    step(1);
    pwr_good = 1'b1;
    step(8);
    push("R9", OBS_FAULT, 4'd1);
    push("R9", OBS_EMUOE, 4'b11);
    step(1);

    // R8: fresh acknowledge now releases; holds drop with it
    flip_ack();
    step(3);
    push("R8", OBS_FAULT, 4'd0);
    push("R7", OBS_EMUOE, 4'b00);
    push("R8", OBS_OE, 4'b111);
    step(1);

    // R10: brief power glitch sets the flag, power return alone keeps it
    pwr_good = 1'b0;
    step(1);
    pwr_good = 1'b1;
    step(8);
    push("R10", OBS_FAULT, 4'd1);
    push("R10", OBS_OE, 4'b000);
    step(1);
    flip_ack();
    step(4);
    push("R10", OBS_FAULT, 4'd0);
    step(1);

    // R11: power loss and acknowledge together -> set wins
    pwr_good = 1'b0;
    flip_ack();
    step(6);
    push("R11", OBS_FAULT, 4'd1);
    step(1);
    pwr_good = 1'b1;
    step(6);
    push("R11", OBS_FAULT, 4'd1);
    step(2);

    done = 1'b1;
    finish_run();
  end
endmodule